// File: doc/BRIEF.md
# Serial-Interface EEPROM Slave

This block behaves as the slave side of a 25-series style serial EEPROM on a four-wire SPI link (mode 0: data taken on the rising serial clock). A host selects it by pulling the active-low select line, then shifts in an 8-bit command, MSB first. Array commands carry a 16-bit address next. Only the low address bits that fit the array are kept. Data bytes follow the address. The block holds a byte array and a small status register. The status register has a write-enable latch and two block-protect bits, and these decide which array writes take effect.

The serial pins are asynchronous to the system clock. Select, serial clock, serial data in and hold each pass through a two-stage synchroniser. Serial-clock edges are then detected in the system clock domain, so the serial clock must run well below the system clock. The array size is set by a parameter. The protected regions follow it as the top quarter and the top half of the array.

Top module: `spie_slave`

## Requirements
- R1: Whenever select is high, the block drops any command in progress, clears its bit counter and its opcode, returns to collecting a command and drives serial data out low. A command interrupted part way leaves the array unchanged.
- R2: With select low and hold high, one bit of data in is taken MSB first on each rising edge of the serial clock. This applies to the command, the address and the write data.
- R3: Command 0x06 sets status bit 1, the write-enable latch. Command 0x04 clears it. Both then ignore the clock until select goes high.
- R4: Command 0x05 returns the status byte MSB first. Bits 3:2 hold the block-protect value, bit 1 the write-enable latch, and every other bit reads 0. The byte repeats for as long as clocking continues.
- R5: Command 0x01 takes one data byte and copies its bits 3:2 into the block-protect field. It keeps the write-enable latch and does not need the latch to be set.
- R6: Command 0x03 takes a 16-bit address and discards the bits above the array width. It then returns array bytes MSB first. Each output bit changes on a rising serial-clock edge. After each byte the address increments and wraps from the last location to 0.
- R7: Command 0x02 takes a 16-bit address and then data bytes. After each byte only the low 7 address bits increment, so a long write wraps inside its 128-byte page.
- R8: An array write takes effect only while the write-enable latch is set. A write does not clear the latch.
- R9: Block-protect value 00 protects nothing. Value 01 protects the top quarter of the array, 10 the top half and 11 the whole array. Writes to a protected byte are dropped.
- R10: Any other command code makes the block ignore the clock until select goes high. Data out stays low and neither the array nor the status register changes.
- R11: While hold is low, serial-clock edges are ignored. The bit counter, the collected bits and data out keep their values.
- R12: After reset, every array byte and the status register read 0 and data out is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| sck_i | input | 1 | Serial clock from the host |
| cs_ni | input | 1 | Active-low select |
| sdi_i | input | 1 | Serial data from the host |
| hold_ni | input | 1 | Active-low hold; clock edges are ignored while low |
| sdo_o | output | 1 | Serial data to the host |

## Verification
The effects of most internal faults are delayed. A bad bit counter or opcode register is seen in the first command after it goes wrong: the status byte read back is wrong, or a read returns the wrong data. A fault in the write path or the protection gate stays hidden until the affected location is read back. For that reason every array write in the bench is later compared against a byte-level reference model through a read. A wrong page-increment or read-increment shows up at the first byte that crosses a page or the array end.

// File: rtl/spie_pkg.sv
package spie_pkg;

  typedef enum logic [2:0] {
    ST_OPC   = 3'd0,
    ST_ADDR  = 3'd1,
    ST_WDATA = 3'd2,
    ST_RDATA = 3'd3,
    ST_IDLE  = 3'd4
  } spie_state_e;

  localparam logic [7:0] OP_WRSR = 8'h01;
  localparam logic [7:0] OP_WRITE = 8'h02;
  localparam logic [7:0] OP_READ = 8'h03;
  localparam logic [7:0] OP_WRDI = 8'h04;
  localparam logic [7:0] OP_RDSR = 8'h05;
  localparam logic [7:0] OP_WREN = 8'h06;

  localparam int PAGE_W = 7;

endpackage

// File: rtl/spie_sync.sv
module spie_sync #(
  parameter int W = 1,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);

  logic [STAGES-1:0][W-1:0] stg_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stg_q <= {STAGES{RST_VAL}};
    end else begin
      stg_q <= {stg_q[STAGES-2:0], d_i};
    end
  end

  assign q_o = stg_q[STAGES-1];

endmodule

// File: rtl/spie_mem.sv
module spie_mem #(
  parameter int AW = 11,
  parameter int DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic [AW-1:0] raddr_i,
  output logic [DW-1:0] rdata_o
);

  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) begin
        mem_q[i] <= '0;
      end
    end else if (we_i) begin
      mem_q[waddr_i] <= wdata_i;
    end
  end

  assign rdata_o = mem_q[raddr_i];

  // R8: a location changes only in a cycle with a write strobe
  a_r8_mem_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(we_i) |-> (mem_q[$past(raddr_i)] == $past(rdata_o)));

endmodule

// File: rtl/spie_guard.sv
module spie_guard #(
  parameter int AW = 11
) (
  input  logic [AW-1:0] addr_i,
  input  logic [1:0]    bp_i,
  input  logic          wel_i,
  output logic          allow_o
);

  logic in_top_quarter;
  logic in_top_half;
  logic region_ok;

  assign in_top_quarter = &addr_i[AW-1 -: 2];
  assign in_top_half    = addr_i[AW-1];

  always_comb begin
    unique case (bp_i)
      2'b00:   region_ok = 1'b1;
      2'b01:   region_ok = !in_top_quarter;
      2'b10:   region_ok = !in_top_half;
      default: region_ok = 1'b0;
    endcase
  end

  assign allow_o = wel_i && region_ok;

  // R9: full protection never lets a write through
  always_comb begin
    if (bp_i == 2'b11) begin
      a_r9_full_block: assert (!allow_o);
    end
  end

endmodule

// File: rtl/spie_slave.sv
module spie_slave #(
  parameter int ADDR_W = 11,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sck_i,
  input  logic cs_ni,
  input  logic sdi_i,
  input  logic hold_ni,
  output logic sdo_o
);
  import spie_pkg::*;

  localparam int CNT_W = 4;
  localparam logic [ADDR_W-1:0] PAGE_MASK = ADDR_W'((1 << PAGE_W) - 1);

  // pin synchronisation: {sck, cs_n, sdi, hold_n}
  logic [3:0] pins_s;
  logic       s_sck;
  logic       s_csn;
  logic       s_sdi;
  logic       s_holdn;

  spie_sync #(
    .W       (4),
    .STAGES  (SYNC_STAGES),
    .RST_VAL (4'b0101)
  ) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    ({sck_i, cs_ni, sdi_i, hold_ni}),
    .q_o    (pins_s)
  );

  assign {s_sck, s_csn, s_sdi, s_holdn} = pins_s;

  // registered state
  spie_state_e       state_q, state_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [7:0]        opc_q, opc_d;
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic [7:0]        buf_q, buf_d;
  logic              wel_q, wel_d;
  logic [1:0]        bp_q, bp_d;
  logic              sdo_q, sdo_d;
  logic              sck_d1_q;

  // derived
  logic              sck_rise;
  logic [7:0]        opc_full;
  logic [7:0]        byte_full;
  logic [ADDR_W-1:0] addr_full;
  logic [7:0]        status_byte;
  logic [ADDR_W-1:0] rd_addr;
  logic [7:0]        rd_data;
  logic              wr_allow;
  logic              mem_we;

  assign sck_rise    = s_sck && !sck_d1_q && !s_csn && s_holdn;
  assign opc_full    = {opc_q[6:0], s_sdi};
  assign byte_full   = {buf_q[6:0], s_sdi};
  assign addr_full   = {addr_q[ADDR_W-2:0], s_sdi};
  assign status_byte = {4'b0000, bp_q, wel_q, 1'b0};
  assign rd_addr     = (state_q == ST_ADDR) ? addr_full : addr_q + 1'b1;

  spie_mem #(
    .AW (ADDR_W),
    .DW (8)
  ) u_mem (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (mem_we),
    .waddr_i (addr_q),
    .wdata_i (byte_full),
    .raddr_i (rd_addr),
    .rdata_o (rd_data)
  );

  spie_guard #(
    .AW (ADDR_W)
  ) u_guard (
    .addr_i  (addr_q),
    .bp_i    (bp_q),
    .wel_i   (wel_q),
    .allow_o (wr_allow)
  );

  // next-state logic
  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    opc_d   = opc_q;
    addr_d  = addr_q;
    buf_d   = buf_q;
    wel_d   = wel_q;
    bp_d    = bp_q;
    sdo_d   = sdo_q;
    mem_we  = 1'b0;

    if (s_csn) begin
      state_d = ST_OPC;
      cnt_d   = '0;
      opc_d   = '0;
      sdo_d   = 1'b0;
    end else if (sck_rise) begin
      unique case (state_q)
        ST_OPC: begin
          opc_d = opc_full;
          cnt_d = cnt_q + 1'b1;
          if (cnt_q == CNT_W'(7)) begin
            cnt_d = '0;
            unique case (opc_full)
              OP_READ, OP_WRITE: state_d = ST_ADDR;
              OP_WRDI: begin
                wel_d   = 1'b0;
                state_d = ST_IDLE;
              end
              OP_WREN: begin
                wel_d   = 1'b1;
                state_d = ST_IDLE;
              end
              OP_RDSR: begin
                buf_d   = status_byte;
                state_d = ST_RDATA;
              end
              OP_WRSR: begin
                buf_d   = '0;
                state_d = ST_WDATA;
              end
              default: state_d = ST_IDLE;
            endcase
          end
        end
        ST_ADDR: begin
          addr_d = addr_full;
          cnt_d  = cnt_q + 1'b1;
          if (cnt_q == CNT_W'(15)) begin
            cnt_d = '0;
            if (opc_q[0]) begin
              buf_d   = rd_data;
              state_d = ST_RDATA;
            end else begin
              buf_d   = '0;
              state_d = ST_WDATA;
            end
          end
        end
        ST_WDATA: begin
          buf_d = byte_full;
          cnt_d = cnt_q + 1'b1;
          if (cnt_q == CNT_W'(7)) begin
            cnt_d = '0;
            buf_d = '0;
            if (opc_q[0]) begin
              bp_d    = byte_full[3:2];
              state_d = ST_IDLE;
            end else begin
              mem_we = wr_allow;
              addr_d = (addr_q & ~PAGE_MASK) | ((addr_q + 1'b1) & PAGE_MASK);
            end
          end
        end
        ST_RDATA: begin
          sdo_d = buf_q[7];
          buf_d = {buf_q[6:0], 1'b0};
          cnt_d = cnt_q + 1'b1;
          if (cnt_q == CNT_W'(7)) begin
            cnt_d = '0;
            if (opc_q == OP_READ) begin
              addr_d = rd_addr;
              buf_d  = rd_data;
            end else begin
              buf_d = status_byte;
            end
          end
        end
        default: begin
          state_d = ST_IDLE;
        end
      endcase
    end
  end

  // registers
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_OPC;
      cnt_q    <= '0;
      opc_q    <= '0;
      addr_q   <= '0;
      buf_q    <= '0;
      wel_q    <= 1'b0;
      bp_q     <= 2'b00;
      sdo_q    <= 1'b0;
      sck_d1_q <= 1'b0;
    end else begin
      state_q  <= state_d;
      cnt_q    <= cnt_d;
      opc_q    <= opc_d;
      addr_q   <= addr_d;
      buf_q    <= buf_d;
      wel_q    <= wel_d;
      bp_q     <= bp_d;
      sdo_q    <= sdo_d;
      sck_d1_q <= s_sck;
    end
  end

  assign sdo_o = sdo_q;

  // assertions
  a_r1_abort: assert property (@(posedge clk_i) disable iff (!rst_ni)
    s_csn |=> (state_q == ST_OPC && cnt_q == '0 && opc_q == '0 && !sdo_o));

  a_r3_wel_source: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(wel_q) |-> ($past(state_q) == ST_OPC));

  a_r5_bp_source: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(bp_q) |-> ($past(state_q) == ST_WDATA && $past(opc_q) == OP_WRSR));

  a_r7_page_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_WDATA) |=> ((addr_q & ~PAGE_MASK) == $past(addr_q & ~PAGE_MASK)));

  a_r8_we_needs_wel: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we |-> (wel_q && bp_q != 2'b11 && state_q == ST_WDATA));

  a_r10_idle_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_IDLE && !s_csn) |=> (state_q == ST_IDLE && !sdo_o));

  a_r11_hold_freeze: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!s_holdn && !s_csn) |=> ($stable(state_q) && $stable(cnt_q) && $stable(sdo_o)));

endmodule

// File: tb/spie_slave_tb.sv
module spie_slave_tb_top;

  localparam int AW = 9;
  localparam int DEPTH = 1 << AW;
  localparam int HALF = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sck = 1'b0;
  logic csn = 1'b1;
  logic mosi = 1'b0;
  logic holdn = 1'b1;
  logic miso;

  int n_chk = 0;
  int n_bad = 0;

  logic [7:0] ref_mem [DEPTH];
  logic       ref_wel;
  logic [1:0] ref_bp;

  always #4 clk = ~clk;

  spie_slave #(.ADDR_W(AW), .SYNC_STAGES(2)) dut_i (
    .clk_i   (clk),
    .rst_ni  (rst_n),
    .sck_i   (sck),
    .cs_ni   (csn),
    .sdi_i   (mosi),
    .hold_ni (holdn),
    .sdo_o   (miso)
  );

  task automatic chk(input string req, input logic [7:0] got, input logic [7:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %02h expected %02h", req, got, exp);
    end
  endtask

  function automatic logic [7:0] exp_status();
    return {4'b0000, ref_bp, ref_wel, 1'b0};
  endfunction

  function automatic bit ref_blocked(input int a);
    case (ref_bp)
      2'b00:   return 1'b0;
      2'b01:   return a >= (DEPTH * 3) / 4;
      2'b10:   return a >= DEPTH / 2;
      default: return 1'b1;
    endcase
  endfunction

  function automatic int page_next(input int a);
    return (a & ~127) | ((a + 1) & 127);
  endfunction

  task automatic xfer_bits(input logic [7:0] tx, input int nbits, output logic [7:0] rx);
    rx = '0;
    for (int i = 7; i > 7 - nbits; i--) begin
      mosi = tx[i];
      repeat (HALF) @(negedge clk);
      sck = 1'b1;
      repeat (HALF) @(negedge clk);
      rx[i] = miso;
      sck = 1'b0;
    end
  endtask

  task automatic xfer(input logic [7:0] tx, output logic [7:0] rx);
    xfer_bits(tx, 8, rx);
  endtask

  task automatic cs_on();
    csn = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  task automatic cs_off();
    repeat (4) @(negedge clk);
    csn = 1'b1;
    repeat (8) @(negedge clk);
  endtask

  task automatic cmd1(input logic [7:0] op);
    logic [7:0] rx;
    cs_on();
    xfer(op, rx);
    cs_off();
    if (op == 8'h06) ref_wel = 1'b1;
    if (op == 8'h04) ref_wel = 1'b0;
  endtask

  task automatic wrsr(input logic [7:0] v);
    logic [7:0] rx;
    cs_on();
    xfer(8'h01, rx);
    xfer(v, rx);
    cs_off();
    ref_bp = v[3:2];
  endtask

  task automatic rdsr_chk(input string req);
    logic [7:0] rx;
    cs_on();
    xfer(8'h05, rx);
    xfer(8'h00, rx);
    chk(req, rx, exp_status());
    xfer(8'h00, rx);
    chk({req, " R4 repeat"}, rx, exp_status());
    cs_off();
  endtask

  task automatic wr_bytes(input logic [15:0] a16, input int n, input logic [7:0] d0, input bit rnd);
    logic [7:0] rx;
    logic [7:0] d;
    int a;
    a = int'(a16) % DEPTH;
    cs_on();
    xfer(8'h02, rx);
    xfer(a16[15:8], rx);
    xfer(a16[7:0], rx);
    for (int i = 0; i < n; i++) begin
      d = rnd ? 8'($urandom) : d0 + 8'(8'h11 * i);
      xfer(d, rx);
      if (ref_wel && !ref_blocked(a)) ref_mem[a] = d;
      a = page_next(a);
    end
    cs_off();
  endtask

  task automatic rd_chk(input logic [15:0] a16, input int n, input string req);
    logic [7:0] rx;
    int a;
    a = int'(a16) % DEPTH;
    cs_on();
    xfer(8'h03, rx);
    xfer(a16[15:8], rx);
    xfer(a16[7:0], rx);
    for (int i = 0; i < n; i++) begin
      xfer(8'h00, rx);
      chk(req, rx, ref_mem[a]);
      a = (a + 1) % DEPTH;
    end
    cs_off();
  endtask

  // watchdog
  initial begin
    repeat (190000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [7:0] rx;
    void'($urandom(32'h5EED_1234));
    for (int i = 0; i < DEPTH; i++) ref_mem[i] = '0;
    ref_wel = 1'b0;
    ref_bp  = 2'b00;

    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);

    // R12 reset state
    chk("R12 sdo idle", {7'd0, miso}, 8'h00);
    rdsr_chk("R12 status zero");
    rd_chk(16'h0000, 2, "R12 array zero");
    rd_chk(16'h01FF, 1, "R12 array zero top");

    // R3 latch set / clear
    cmd1(8'h06);
    rdsr_chk("R3 wel set");
    cmd1(8'h04);
    rdsr_chk("R3 wel clear");

    // R8 gating by latch
    wr_bytes(16'h0010, 1, 8'h55, 1'b0);
    rd_chk(16'h0010, 1, "R8 write dropped without wel");
    cmd1(8'h06);
    wr_bytes(16'h0010, 2, 8'h55, 1'b0);
    rd_chk(16'h0010, 2, "R8 write with wel");
    rdsr_chk("R8 wel kept after write");

    // R7 page wrap
    wr_bytes(16'h00FE, 4, 8'hA0, 1'b0);
    rd_chk(16'h0080, 2, "R7 page wrap low end");
    rd_chk(16'h00FE, 3, "R7 page wrap no spill");

    // R6 read rollover and high-bit discard
    wr_bytes(16'h01FF, 1, 8'h3C, 1'b0);
    wr_bytes(16'h0000, 1, 8'hC3, 1'b0);
    rd_chk(16'h01FF, 3, "R6 read rollover");
    wr_bytes(16'hFE44, 1, 8'h9A, 1'b0);
    rd_chk(16'h0044, 1, "R6 upper addr bits discarded");
    rd_chk(16'hA244, 1, "R6 upper addr bits discarded rd");

    // R9 protection regions
    wrsr(8'h04);
    rdsr_chk("R5 bp 01");
    wr_bytes(16'd384, 1, 8'h71, 1'b0);
    wr_bytes(16'd383, 1, 8'h72, 1'b0);
    rd_chk(16'd383, 2, "R9 top quarter");
    wrsr(8'h08);
    wr_bytes(16'd256, 1, 8'h73, 1'b0);
    wr_bytes(16'd255, 1, 8'h74, 1'b0);
    rd_chk(16'd255, 2, "R9 top half");
    wrsr(8'h0C);
    wr_bytes(16'd5, 1, 8'h75, 1'b0);
    wr_bytes(16'd500, 1, 8'h76, 1'b0);
    rd_chk(16'd5, 1, "R9 full low");
    rd_chk(16'd500, 1, "R9 full high");
    wrsr(8'h00);
    wr_bytes(16'd500, 1, 8'h77, 1'b0);
    rd_chk(16'd500, 1, "R9 none");

    // R5 field masking and no latch needed
    wrsr(8'hFF);
    rdsr_chk("R5 only bits 3:2");
    cmd1(8'h04);
    wrsr(8'hF3);
    rdsr_chk("R5 without wel");
    cmd1(8'h06);

    // R10 unknown opcode
    cs_on();
    xfer(8'hAB, rx);
    chk("R10 sdo low", rx, 8'h00);
    xfer(8'h02, rx);
    chk("R10 sdo low", rx, 8'h00);
    xfer(8'h00, rx);
    xfer(8'h20, rx);
    xfer(8'h5A, rx);
    chk("R10 sdo low", rx, 8'h00);
    cs_off();
    rd_chk(16'h0020, 1, "R10 array unchanged");
    rdsr_chk("R10 status unchanged");

    // R1 abort mid write and mid read
    cs_on();
    xfer(8'h02, rx);
    xfer(8'h00, rx);
    xfer(8'h30, rx);
    xfer_bits(8'hFF, 5, rx);
    cs_off();
    rd_chk(16'h0030, 1, "R1 aborted write");
    cs_on();
    xfer(8'h03, rx);
    xfer(8'h00, rx);
    xfer(8'h10, rx);
    xfer_bits(8'h00, 3, rx);
    cs_off();
    chk("R1 sdo low after abort", {7'd0, miso}, 8'h00);
    rd_chk(16'h0010, 1, "R1 fresh command after abort");

    // R11 hold ignores clock edges
    cmd1(8'h04);
    cs_on();
    xfer_bits(8'h06, 4, rx);
    holdn = 1'b0;
    repeat (HALF) @(negedge clk);
    for (int k = 0; k < 4; k++) begin
      mosi = 1'b1;
      repeat (HALF) @(negedge clk);
      sck = 1'b1;
      repeat (HALF) @(negedge clk);
      sck = 1'b0;
    end
    repeat (HALF) @(negedge clk);
    holdn = 1'b1;
    repeat (HALF) @(negedge clk);
    xfer_bits(8'h60, 4, rx);
    cs_off();
    ref_wel = 1'b1;
    rdsr_chk("R11 hold ignored edges");

    // R2 random traffic against the model
    for (int t = 0; t < 90; t++) begin
      int op;
      op = $urandom_range(0, 7);
      case (op)
        0: cmd1(8'h06);
        1: cmd1(($urandom_range(0, 2) == 0) ? 8'h04 : 8'h06);
        2: wrsr(($urandom_range(0, 3) == 0) ? 8'($urandom) : 8'h00);
        3, 4, 5: wr_bytes(16'($urandom), $urandom_range(1, 4), 8'h00, 1'b1);
        6: rd_chk(16'($urandom), $urandom_range(1, 3), "R2 random read");
        default: rdsr_chk("R2 random status");
      endcase
    end
    for (int a = 0; a < DEPTH; a += 64) begin
      rd_chk(16'(a), 4, "R2 final sweep");
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule